// File: doc/BRIEF.md
# Bank-Swizzle Operand Read Scheduler

This block plans the general-register reads for one instruction group made of four vector ALU slots. Each slot carries three source operands. Every operand has a kind, a register index and a channel, and each slot has a 3-bit swizzle code. For operands that come from general registers, the swizzle code picks which of the three read cycles (0, 1, 2) fetches each one. The block collects the reads of all four slots into a read-port request per cycle and per channel bank. It flags the group when two different registers would need the same bank in the same cycle.

For each slot it then steers the data onto src0, src1 and src2. Register data comes from a read-data bus that carries one four-element vector per cycle. Constant data comes from a constant bus that has the same shape. A constant operand always takes the constant vector of the cycle that matches its operand position.

The group descriptor is registered when `grp_valid` is high. All outputs follow from that registered group one clock later, and they stay valid for as long as `out_valid` is high.

Top module: `opnd_read_sched`

## Requirements
- R1: After synchronous reset every output is zero. `out_valid` is high exactly in the cycle after a cycle in which `grp_valid` was sampled high out of reset.
- R2: Swizzle codes set the read cycles of (src0, src1, src2) as follows: 0 gives (0,1,2), 1 gives (0,2,1), 2 gives (1,2,0), 3 gives (1,0,2), 4 gives (2,0,1) and 5 gives (2,1,0).
- R3: A slot with swizzle code 6 or 7 makes the group conflict. The general-register operands of that slot issue no read request.
- R4: Two general-register operands anywhere in the group that map to the same cycle and the same channel bank, with different indices, raise `conflict`.
- R5: Operands that share a cycle, a bank and a register index do not conflict, and they are served by one request.
- R6: A constant operand in position N routes cycle N and its own channel from `k_data`, whatever the swizzle code is. It makes no read request.
- R7: When `out_valid` is high, `rq_en` bit c*4+b is set exactly when some general-register operand reads bank b in cycle c. `rq_index` then carries the index of the first such operand in operand order, and is zero otherwise. Both buses are zero when `out_valid` is low.
- R8: A routed general-register operand in slot s, position o, gets the element of `rd_data` for its read cycle and channel on `src_data`.
- R9: When `conflict` is high, `route_valid` is low and both `route_sel` and `src_data` are all zero.
- R10: Operand kinds 0 (unused) and 3 (reserved) make no request, and their `route_sel` and `src_data` fields are zero.
- R11: Each `route_sel` field holds, from MSB to LSB: used, constant, cycle[1:0] and bank[1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | Descriptor on the inputs is a new group |
| grp_kind | input | 24 | Per operand (slot*3+pos), 2 bits: 0 unused, 1 register, 2 constant, 3 reserved |
| grp_index | input | 84 | Per operand, register index |
| grp_chan | input | 24 | Per operand, channel 0..3 (X..W) |
| grp_swz | input | 12 | Per slot, 3-bit swizzle code |
| rd_data | input | 384 | Register data, element c*4+b is cycle c, bank b |
| k_data | input | 384 | Constant data, same layout as rd_data |
| out_valid | output | 1 | Registered group present |
| conflict | output | 1 | Group breaks a read-port limit or uses an illegal code |
| rq_en | output | 12 | Read enable per cycle and bank |
| rq_index | output | 84 | Register index per cycle and bank |
| route_valid | output | 1 | Routing outputs are usable |
| route_sel | output | 72 | Per operand routing select, 6 bits |
| src_data | output | 384 | Per operand steered data |

## Verification
On every cycle the assertions check four things. The one-cycle latency of `out_valid` holds. Illegal codes block routing. A suppressed group leaves the routing and data outputs silent. Every routed register operand has a matching enabled read port that carries its index. They also check that constant selects keep their own cycle, that each legal code is a true permutation, and that a clash is only reported when at least two requests exist. Only the directed scenarios can show that the six permutations land on the exact cycles listed, that a clash can be cured by changing one slot's code, that shared indices merge into a single request, and that the steered data values are right.

// File: rtl/rdsched_pkg.sv
`timescale 1ns/1ps
package rdsched_pkg;

    localparam int unsigned NUM_CYC      = 3;
    localparam int unsigned NUM_BANK     = 4;
    localparam int unsigned OPS_PER_SLOT = 3;
    localparam int unsigned NUM_PORT     = NUM_CYC * NUM_BANK;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_GPR   = 2'd1,
        OPK_CONST = 2'd2,
        OPK_RSVD  = 2'd3
    } opk_e;

    localparam logic [2:0] SWZ_012 = 3'd0;
    localparam logic [2:0] SWZ_021 = 3'd1;
    localparam logic [2:0] SWZ_120 = 3'd2;
    localparam logic [2:0] SWZ_102 = 3'd3;
    localparam logic [2:0] SWZ_201 = 3'd4;
    localparam logic [2:0] SWZ_210 = 3'd5;

    typedef struct packed {
        logic       used;
        logic       is_const;
        logic [1:0] cyc;
        logic [1:0] bank;
    } route_t;

    function automatic logic swz_legal(input logic [2:0] code);
        return code <= SWZ_210;
    endfunction

    // read cycle for source position op under a swizzle code
    function automatic logic [1:0] swz_cycle(input logic [2:0] code, input logic [1:0] op);
        logic [1:0] c0, c1, c2;
        case (code)
            SWZ_021: begin c0 = 2'd0; c1 = 2'd2; c2 = 2'd1; end
            SWZ_120: begin c0 = 2'd1; c1 = 2'd2; c2 = 2'd0; end
            SWZ_102: begin c0 = 2'd1; c1 = 2'd0; c2 = 2'd2; end
            SWZ_201: begin c0 = 2'd2; c1 = 2'd0; c2 = 2'd1; end
            SWZ_210: begin c0 = 2'd2; c1 = 2'd1; c2 = 2'd0; end
            default: begin c0 = 2'd0; c1 = 2'd1; c2 = 2'd2; end
        endcase
        case (op)
            2'd0:    return c0;
            2'd1:    return c1;
            default: return c2;
        endcase
    endfunction

    // pick element (cyc, bank) of a per-cycle vector bus
    function automatic logic [31:0] pick_word(input logic [NUM_PORT*32-1:0] bus,
                                              input logic [1:0] cyc, input logic [1:0] bank);
        int unsigned p;
        p = 32'(cyc) * NUM_BANK + 32'(bank);
        if (cyc < 2'(NUM_CYC)) return bus[p*32 +: 32];
        return '0;
    endfunction

endpackage

// File: rtl/rdsched_slot_map.sv
`timescale 1ns/1ps
module rdsched_slot_map
    import rdsched_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [2*OPS_PER_SLOT-1:0]   kind,
    input  logic [2*OPS_PER_SLOT-1:0]   chan,
    input  logic [2:0]                  swz,
    output route_t [OPS_PER_SLOT-1:0]   route,
    output logic [OPS_PER_SLOT-1:0]     gpr_req,
    output logic                        illegal
);

    logic [1:0] perm [OPS_PER_SLOT];

    always_comb begin
        illegal = !swz_legal(swz);
        for (int o = 0; o < OPS_PER_SLOT; o++) begin
            opk_e k;
            logic is_gpr, is_k;
            k       = opk_e'(kind[2*o +: 2]);
            is_gpr  = (k == OPK_GPR);
            is_k    = (k == OPK_CONST);
            perm[o] = swz_cycle(swz, 2'(o));
            route[o].used     = is_gpr | is_k;
            route[o].is_const = is_k;
            route[o].cyc      = is_k ? 2'(o) : (is_gpr ? perm[o] : 2'd0);
            route[o].bank     = (is_gpr | is_k) ? chan[2*o +: 2] : 2'd0;
            gpr_req[o]        = is_gpr & !illegal;
        end
    end

    AST_SWZ_PERMUTES: assert property (@(posedge clk) disable iff (rst)
        !illegal |-> (perm[0] != perm[1] && perm[0] != perm[2] && perm[1] != perm[2])) // R2
        else $error("AST_SWZ_PERMUTES");

endmodule

// File: rtl/rdsched_port_check.sv
`timescale 1ns/1ps
module rdsched_port_check #(
    parameter int unsigned N_REQ = 12,
    parameter int unsigned IDX_W = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_REQ-1:0]       req,
    input  logic [N_REQ*IDX_W-1:0] idx,
    output logic                   en,
    output logic [IDX_W-1:0]       index,
    output logic                   clash
);

    always_comb begin
        en    = 1'b0;
        index = '0;
        clash = 1'b0;
        for (int j = 0; j < N_REQ; j++) begin
            if (req[j]) begin
                if (!en) begin
                    en    = 1'b1;
                    index = idx[j*IDX_W +: IDX_W];
                end else if (idx[j*IDX_W +: IDX_W] != index) begin
                    clash = 1'b1;
                end
            end
        end
    end

    AST_CLASH_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
        clash |-> ($countones(req) >= 2)) // R4
        else $error("AST_CLASH_NEEDS_TWO");

endmodule

// File: rtl/rdsched_router.sv
`timescale 1ns/1ps
module rdsched_router
    import rdsched_pkg::*;
#(
    parameter int unsigned N_OPND = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pass,
    input  route_t [N_OPND-1:0]          sel_in,
    input  logic [NUM_PORT*DATA_W-1:0]   gpr_vec,
    input  logic [NUM_PORT*DATA_W-1:0]   k_vec,
    output route_t [N_OPND-1:0]          sel_out,
    output logic [N_OPND*DATA_W-1:0]     src
);

    function automatic logic [DATA_W-1:0] take(input logic [NUM_PORT*DATA_W-1:0] bus,
                                               input logic [1:0] cyc, input logic [1:0] bank);
        int unsigned p;
        p = 32'(cyc) * NUM_BANK + 32'(bank);
        if (cyc < 2'(NUM_CYC)) return bus[p*DATA_W +: DATA_W];
        return '0;
    endfunction

    always_comb begin
        for (int j = 0; j < N_OPND; j++) begin
            sel_out[j] = pass ? sel_in[j] : '0;
            if (!sel_out[j].used)
                src[j*DATA_W +: DATA_W] = '0;
            else if (sel_out[j].is_const)
                src[j*DATA_W +: DATA_W] = take(k_vec, sel_out[j].cyc, sel_out[j].bank);
            else
                src[j*DATA_W +: DATA_W] = take(gpr_vec, sel_out[j].cyc, sel_out[j].bank);
        end
    end

    AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pass |-> (sel_out == '0 && src == '0)) // R9
        else $error("AST_BLOCKED_QUIET");

    for (genvar j = 0; j < N_OPND; j++) begin : g_kchk
        localparam logic [1:0] POS = 2'(j % OPS_PER_SLOT);
        AST_CONST_OWN_CYCLE: assert property (@(posedge clk) disable iff (rst)
            (sel_out[j].used && sel_out[j].is_const) |-> (sel_out[j].cyc == POS)) // R6
            else $error("AST_CONST_OWN_CYCLE");
    end

endmodule

// File: rtl/opnd_read_sched.sv
`timescale 1ns/1ps
module opnd_read_sched
    import rdsched_pkg::*;
#(
    parameter int unsigned N_SLOT = 4,
    parameter int unsigned IDX_W  = 7,
    parameter int unsigned DATA_W = 32
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   grp_valid,
    input  logic [2*N_SLOT*OPS_PER_SLOT-1:0]       grp_kind,
    input  logic [IDX_W*N_SLOT*OPS_PER_SLOT-1:0]   grp_index,
    input  logic [2*N_SLOT*OPS_PER_SLOT-1:0]       grp_chan,
    input  logic [3*N_SLOT-1:0]                    grp_swz,
    input  logic [NUM_PORT*DATA_W-1:0]             rd_data,
    input  logic [NUM_PORT*DATA_W-1:0]             k_data,
    output logic                                   out_valid,
    output logic                                   conflict,
    output logic [NUM_PORT-1:0]                    rq_en,
    output logic [NUM_PORT*IDX_W-1:0]              rq_index,
    output logic                                   route_valid,
    output logic [6*N_SLOT*OPS_PER_SLOT-1:0]       route_sel,
    output logic [DATA_W*N_SLOT*OPS_PER_SLOT-1:0]  src_data
);

    localparam int unsigned N_OPND = N_SLOT * OPS_PER_SLOT;

    // registered group
    logic                      v_q;
    logic [2*N_OPND-1:0]       kind_q;
    logic [IDX_W*N_OPND-1:0]   idx_q;
    logic [2*N_OPND-1:0]       chan_q;
    logic [3*N_SLOT-1:0]       swz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q    <= 1'b0;
            kind_q <= '0;
            idx_q  <= '0;
            chan_q <= '0;
            swz_q  <= '0;
        end else begin
            v_q <= grp_valid;
            if (grp_valid) begin
                kind_q <= grp_kind;
                idx_q  <= grp_index;
                chan_q <= grp_chan;
                swz_q  <= grp_swz;
            end
        end
    end

    // per-slot swizzle decode
    route_t [N_OPND-1:0] route_all;
    logic [N_OPND-1:0]   req_all;
    logic [N_SLOT-1:0]   bad_swz;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        rdsched_slot_map u_map (
            .clk     (clk),
            .rst     (rst),
            .kind    (kind_q[2*OPS_PER_SLOT*s +: 2*OPS_PER_SLOT]),
            .chan    (chan_q[2*OPS_PER_SLOT*s +: 2*OPS_PER_SLOT]),
            .swz     (swz_q[3*s +: 3]),
            .route   (route_all[OPS_PER_SLOT*s +: OPS_PER_SLOT]),
            .gpr_req (req_all[OPS_PER_SLOT*s +: OPS_PER_SLOT]),
            .illegal (bad_swz[s])
        );
    end

    // per cycle/bank read-port arbitration
    logic [N_OPND-1:0] port_req [NUM_PORT];
    logic [NUM_PORT-1:0] port_en, port_clash;
    logic [NUM_PORT*IDX_W-1:0] port_idx;

    always_comb begin
        for (int p = 0; p < NUM_PORT; p++) begin
            for (int j = 0; j < N_OPND; j++) begin
                port_req[p][j] = req_all[j]
                              && (route_all[j].cyc  == 2'(p / NUM_BANK))
                              && (route_all[j].bank == 2'(p % NUM_BANK));
            end
        end
    end

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        rdsched_port_check #(.N_REQ(N_OPND), .IDX_W(IDX_W)) u_chk (
            .clk   (clk),
            .rst   (rst),
            .req   (port_req[p]),
            .idx   (idx_q),
            .en    (port_en[p]),
            .index (port_idx[p*IDX_W +: IDX_W]),
            .clash (port_clash[p])
        );
    end

    logic conflict_any;
    assign conflict_any = (|port_clash) | (|bad_swz);

    assign out_valid   = v_q;
    assign conflict    = v_q & conflict_any;
    assign route_valid = v_q & ~conflict_any;
    assign rq_en       = v_q ? port_en  : '0;
    assign rq_index    = v_q ? port_idx : '0;

    // operand steering
    route_t [N_OPND-1:0] sel_out;

    rdsched_router #(.N_OPND(N_OPND), .DATA_W(DATA_W)) u_route (
        .clk     (clk),
        .rst     (rst),
        .pass    (route_valid),
        .sel_in  (route_all),
        .gpr_vec (rd_data),
        .k_vec   (k_data),
        .sel_out (sel_out),
        .src     (src_data)
    );

    assign route_sel = sel_out;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(grp_valid && !rst)) // R1
        else $error("AST_VALID_LATENCY");

    AST_ILLEGAL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (|bad_swz)) |-> (conflict && !route_valid)) // R3
        else $error("AST_ILLEGAL_BLOCKS");

    // every routed register operand finds its own read port enabled
    for (genvar j = 0; j < N_OPND; j++) begin : g_rdchk
        logic             hit_en;
        logic [IDX_W-1:0] hit_idx;
        always_comb begin
            int unsigned p;
            p       = 32'(sel_out[j].cyc) * NUM_BANK + 32'(sel_out[j].bank);
            hit_en  = 1'b0;
            hit_idx = '0;
            if (sel_out[j].cyc < 2'(NUM_CYC)) begin
                hit_en  = rq_en[p];
                hit_idx = rq_index[p*IDX_W +: IDX_W];
            end
        end
        AST_ROUTED_READ_ISSUED: assert property (@(posedge clk) disable iff (rst)
            (route_valid && sel_out[j].used && !sel_out[j].is_const)
                |-> (hit_en && hit_idx == idx_q[j*IDX_W +: IDX_W])) // R7
            else $error("AST_ROUTED_READ_ISSUED");
    end

endmodule

// File: tb/test_opnd_read_sched.sv
`timescale 1ns/1ps
module test_opnd_read_sched;

    localparam int NS = 4, NO = 12, IW = 7, DW = 32, NP = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              grp_valid = 1'b0;
    logic [2*NO-1:0]   grp_kind  = '0;
    logic [IW*NO-1:0]  grp_index = '0;
    logic [2*NO-1:0]   grp_chan  = '0;
    logic [3*NS-1:0]   grp_swz   = '0;
    logic [NP*DW-1:0]  rd_data, k_data;
    logic              out_valid, conflict, route_valid;
    logic [NP-1:0]     rq_en;
    logic [NP*IW-1:0]  rq_index;
    logic [6*NO-1:0]   route_sel;
    logic [DW*NO-1:0]  src_data;

    opnd_read_sched i_opnd_read_sched (
        .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_kind(grp_kind),
        .grp_index(grp_index), .grp_chan(grp_chan), .grp_swz(grp_swz),
        .rd_data(rd_data), .k_data(k_data), .out_valid(out_valid),
        .conflict(conflict), .rq_en(rq_en), .rq_index(rq_index),
        .route_valid(route_valid), .route_sel(route_sel), .src_data(src_data)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // descriptor under test
    int d_kind [NO];
    int d_idx  [NO];
    int d_ch   [NO];
    int d_swz  [NS];

    function automatic logic [31:0] gval(int c, int b); return 32'hA000_0000 | (c << 8) | b; endfunction
    function automatic logic [31:0] kval(int c, int b); return 32'hC000_0000 | (c << 8) | b; endfunction

    initial begin
        for (int c = 0; c < 3; c++)
            for (int b = 0; b < 4; b++) begin
                rd_data[(c*4+b)*DW +: DW] = gval(c, b);
                k_data [(c*4+b)*DW +: DW] = kval(c, b);
            end
    end

    // table from R2
    function automatic int cyc_of(int code, int o);
        int t [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,2,0}, '{1,0,2}, '{2,0,1}, '{2,1,0}};
        return t[code][o];
    endfunction

    task automatic chk(string tag, string what, logic [511:0] act, logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_desc();
        for (int j = 0; j < NO; j++) begin d_kind[j] = 0; d_idx[j] = 0; d_ch[j] = 0; end
        for (int s = 0; s < NS; s++) d_swz[s] = 0;
    endtask

    task automatic apply_and_check(string tag);
        logic          e_conf;
        logic [NP-1:0] e_en;
        logic [NP*IW-1:0] e_idx;
        logic [6*NO-1:0]  e_sel;
        logic [DW*NO-1:0] e_src;
        e_conf = 0; e_en = '0; e_idx = '0; e_sel = '0; e_src = '0;
        for (int s = 0; s < NS; s++) if (d_swz[s] > 5) e_conf = 1;
        for (int j = 0; j < NO; j++) begin
            int s, o, c;
            s = j / 3; o = j % 3;
            if (d_kind[j] == 1 && d_swz[s] <= 5) begin
                int p;
                c = cyc_of(d_swz[s], o);
                p = c*4 + d_ch[j];
                if (!e_en[p]) begin e_en[p] = 1; e_idx[p*IW +: IW] = IW'(d_idx[j]); end
                else if (e_idx[p*IW +: IW] != IW'(d_idx[j])) e_conf = 1;
            end
        end
        if (!e_conf) begin
            for (int j = 0; j < NO; j++) begin
                int s, o, c;
                s = j / 3; o = j % 3;
                if (d_kind[j] == 1) begin
                    c = cyc_of(d_swz[s], o);
                    e_sel[6*j +: 6] = {1'b1, 1'b0, 2'(c), 2'(d_ch[j])};
                    e_src[DW*j +: DW] = gval(c, d_ch[j]);
                end else if (d_kind[j] == 2) begin
                    e_sel[6*j +: 6] = {1'b1, 1'b1, 2'(o), 2'(d_ch[j])};
                    e_src[DW*j +: DW] = kval(o, d_ch[j]);
                end
            end
        end
        @(negedge clk);
        grp_valid = 1'b1;
        for (int j = 0; j < NO; j++) begin
            grp_kind[2*j +: 2]   = 2'(d_kind[j]);
            grp_index[IW*j +: IW] = IW'(d_idx[j]);
            grp_chan[2*j +: 2]   = 2'(d_ch[j]);
        end
        for (int s = 0; s < NS; s++) grp_swz[3*s +: 3] = 3'(d_swz[s]);
        @(negedge clk);
        grp_valid = 1'b0;
        chk(tag, "out_valid",   512'(out_valid),   512'(1));
        chk(tag, "conflict",    512'(conflict),    512'(e_conf));
        chk(tag, "route_valid", 512'(route_valid), 512'(!e_conf));
        chk(tag, "rq_en",       512'(rq_en),       512'(e_en));
        chk(tag, "rq_index",    512'(rq_index),    512'(e_idx));
        chk(tag, "route_sel",   512'(route_sel),   512'(e_sel));
        chk(tag, "src_data",    512'(src_data),    512'(e_src));
    endtask

    task automatic t_reset();
        chk("R1", "reset out_valid", 512'(out_valid), 512'(0));
        chk("R1", "reset conflict",  512'(conflict),  512'(0));
        chk("R1", "reset rq_en",     512'(rq_en),     512'(0));
        chk("R1", "reset route_sel", 512'(route_sel), 512'(0));
        chk("R1", "reset src_data",  512'(src_data),  512'(0));
    endtask

    task automatic own_bank_group();
        clear_desc();
        for (int s = 0; s < NS; s++)
            for (int o = 0; o < 3; o++) begin
                d_kind[s*3+o] = 1; d_ch[s*3+o] = s; d_idx[s*3+o] = s*16 + o + 1;
            end
    endtask

    task automatic t_identity();
        own_bank_group();
        apply_and_check("R2/R7/R8/R11 identity");
        @(negedge clk);
        chk("R1", "valid drops", 512'(out_valid), 512'(0));
        chk("R7", "rq idle",     512'(rq_en),     512'(0));
    endtask

    task automatic t_all_codes();
        own_bank_group();
        d_swz = '{1, 2, 3, 4};
        apply_and_check("R2 codes 1-4");
        d_swz = '{5, 0, 1, 2};
        apply_and_check("R2 codes 5,0");
    endtask

    task automatic t_illegal();
        own_bank_group();
        d_swz[2] = 6;
        apply_and_check("R3/R9 code 6");
        own_bank_group();
        d_swz[0] = 7;
        apply_and_check("R3/R9 code 7");
    endtask

    task automatic t_clash();
        clear_desc();
        d_kind[0] = 1; d_ch[0] = 0; d_idx[0] = 5;
        d_kind[3] = 1; d_ch[3] = 0; d_idx[3] = 9;
        apply_and_check("R4/R9 clash");
        d_swz[1] = 2;
        apply_and_check("R4 cured by swizzle");
        d_swz[1] = 0;
        apply_and_check("R4 clash again");
        own_bank_group();
        apply_and_check("R1 recover");
    endtask

    task automatic t_shared();
        clear_desc();
        d_kind[0] = 1; d_ch[0] = 2; d_idx[0] = 33;
        d_kind[4] = 1; d_ch[4] = 2; d_idx[4] = 33; d_swz[1] = 3;
        d_kind[9] = 1; d_ch[9] = 2; d_idx[9] = 33;
        apply_and_check("R5/R7 shared index");
    endtask

    task automatic t_const();
        clear_desc();
        for (int s = 0; s < NS; s++)
            for (int o = 0; o < 3; o++) begin
                d_kind[s*3+o] = 2; d_ch[s*3+o] = (s + o) % 4;
            end
        d_swz = '{5, 2, 4, 1};
        apply_and_check("R6 all constants");
        d_kind[1] = 1; d_idx[1] = 70; d_ch[1] = 3;
        apply_and_check("R6 mixed");
    endtask

    task automatic t_none();
        clear_desc();
        for (int j = 0; j < NO; j++) begin d_kind[j] = (j % 2) ? 3 : 0; d_idx[j] = j; d_ch[j] = j % 4; end
        d_kind[5] = 1; d_ch[5] = 1; d_idx[5] = 12;
        apply_and_check("R10 unused/reserved");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_identity();
        t_all_codes();
        t_illegal();
        t_clash();
        t_shared();
        t_const();
        t_none();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule